// File: doc/BRIEF.md
# Cycle-Stealing Byte DMA Engine

This block is a single-channel engine that moves bytes between a peripheral and memory with no processor involvement once started. Software loads a starting memory address, a byte count and a direction through a small register port, then sets a start bit. While a transfer is live, the engine asks for the system bus and moves exactly one byte in each cycle where the arbiter grants it the bus and the peripheral is requesting service. After each byte the memory address goes up by one and the remaining count goes down by one.

Consecutive pages are not assumed to be adjacent in physical memory. When a byte lands on the last address of a page and bytes still remain, the engine stops and raises a page-wait status flag. It then waits for software to write the base address of the next page. Writing that address resumes the transfer at the new location. When the count runs out, the engine raises a level interrupt. That interrupt stays high until software writes the status register.

Top module: `dma_steal`

## Requirements
- R1: After reset the engine is idle: `irq`, `busReq`, `memEn` and `devAck` are low, and the status register (select 3) reads 0.
- R2: Selects 0, 1 and 2 hold the address, the count and the direction (control bit 1). Each reads back what was written while the engine is idle. Writing select 2 with bit 0 set and a non-zero count starts a transfer, and status bit 0 (busy) reads 1 while it runs.
- R3: A memory access (`memEn`, with `devAck` in the same cycle) happens only in a cycle where `busGrant`, `busReq` and `devReq` are all high. `busReq` is high only while a transfer is running, not page-waiting, and `devReq` is high.
- R4: With direction 0 (device to memory), each access writes memory (`memWe`=1) with `memWdata` equal to `devRdata`.
- R5: With direction 1 (memory to device), each access reads memory (`memWe`=0) and `devWdata` equals `memRdata`.
- R6: After each byte the address increases by 1 and the count decreases by 1. Reading back the address and count after a transfer shows these totals.
- R7: When a byte is moved at an address whose low PAGE_BITS bits are all ones and count remains, the engine makes no further access. Status bit 1 reads 1 and `busReq` is low until select 0 is written. The transfer then continues from the written address.
- R8: When the last byte is moved, `irq` rises on the next edge and status bit 0 clears.
- R9: A start with a count of 0 moves no data and raises `irq` on the next edge.
- R10: While a transfer is live, writes to the count and control registers are ignored, including a second start. The stored count and direction are left unchanged.
- R11: `irq` stays high until select 3 is written with any value, and goes low on the edge of that write. Status bit 2 mirrors `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for the current select |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus granted for this cycle (processor idle) |
| devReq | input | 1 | Peripheral asks for a byte transfer |
| devAck | output | 1 | Peripheral byte taken or delivered this cycle |
| devRdata | input | 8 | Byte from the peripheral |
| devWdata | output | 8 | Byte to the peripheral |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, combinational from memAddr |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions assume that the arbiter may grant the bus in any cycle, and that software writes the address register only when the engine is idle or page-waiting. They also assume that memory read data is valid in the same cycle as the address. The bench drives grant and peripheral request from fixed-period gaps, so accesses are spread out and stall often. It writes the address only after it has read the page-wait flag, and it models memory as a pure function of the address.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  localparam int REG_W = 32;
  localparam int CTL_START_BIT = 0;
  localparam int CTL_DIR_BIT = 1;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_PWAIT = 2'd2
  } state_e;

  typedef struct packed {
    logic loadAddr;
    logic loadCnt;
    logic loadDir;
    logic step;
  } dpCtl_t;
endpackage

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
  import dma_steal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWe,
  input  logic [1:0]   regSel,
  input  logic         startBit,
  input  logic         busGrant,
  input  logic         devReq,
  input  logic         cntZero,
  input  logic         cntIsOne,
  input  logic         pageLast,
  output dpCtl_t       dpCtl,
  output logic         busReq,
  output logic         busy,
  output logic         pageWait,
  output logic         irq
);
  state_e state;
  logic wrAddr, wrCnt, wrCtl, clrIrq, idle;

  assign idle     = (state == ST_IDLE);
  assign pageWait = (state == ST_PWAIT);
  assign busy     = !idle;
  assign wrAddr   = regWe && (regSel == SEL_ADDR);
  assign wrCnt    = regWe && (regSel == SEL_CNT);
  assign wrCtl    = regWe && (regSel == SEL_CTL);
  assign clrIrq   = regWe && (regSel == SEL_STAT);
  assign busReq   = (state == ST_XFER) && devReq;

  always_comb begin
    dpCtl.loadAddr = wrAddr && (idle || pageWait);
    dpCtl.loadCnt  = wrCnt && idle;
    dpCtl.loadDir  = wrCtl && idle;
    dpCtl.step     = busReq && busGrant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      if (clrIrq) irq <= 1'b0;
      case (state)
        ST_IDLE: if (wrCtl && startBit) begin
          if (cntZero) irq <= 1'b1;
          else state <= ST_XFER;
        end
        ST_XFER: if (dpCtl.step) begin
          if (cntIsOne) begin
            state <= ST_IDLE;
            irq   <= 1'b1;
          end else if (pageLast) begin
            state <= ST_PWAIT;
          end
        end
        ST_PWAIT: if (wrAddr) state <= ST_XFER;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_access_granted_r3: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.step |-> (busGrant && devReq && busy && !pageWait));

  p_page_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.step && pageLast && !cntIsOne) |=> (pageWait && !busReq));

  p_done_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.step && cntIsOne) |=> (irq && !busy));

  p_zero_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idle && wrCtl && startBit && cntZero) |=> (irq && !busy));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrIrq) |=> irq);
endmodule

// File: rtl/dma_steal_dp.sv
module dma_steal_dp
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [REG_W-1:0]  wdata,
  input  logic [DATA_W-1:0] devRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              dir,
  output logic              cntZero,
  output logic              cntIsOne,
  output logic              pageLast,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] devWdata
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
      cnt  <= '0;
      dir  <= 1'b0;
    end else begin
      if (dpCtl.loadAddr) addr <= wdata[ADDR_W-1:0];
      else if (dpCtl.step) addr <= addr + ADDR_ONE;
      if (dpCtl.loadCnt) cnt <= wdata[CNT_W-1:0];
      else if (dpCtl.step) cnt <= cnt - CNT_ONE;
      if (dpCtl.loadDir) dir <= wdata[CTL_DIR_BIT];
    end
  end

  assign cntZero  = (cnt == '0);
  assign cntIsOne = (cnt == CNT_ONE);
  assign pageLast = &addr[PAGE_BITS-1:0];
  assign memWdata = devRdata;
  assign devWdata = memRdata;

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.step && !dpCtl.loadAddr) |=> (addr == $past(addr) + ADDR_ONE));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.step && !dpCtl.loadCnt) |=> (cnt == $past(cnt) - CNT_ONE));
endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              busReq,
  input  logic              busGrant,
  input  logic              devReq,
  output logic              devAck,
  input  logic [DATA_W-1:0] devRdata,
  output logic [DATA_W-1:0] devWdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq
);
  dpCtl_t dpCtl;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] cnt;
  logic dir, cntZero, cntIsOne, pageLast, busy, pageWait;

  dma_steal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .startBit(regWdata[CTL_START_BIT]), .busGrant(busGrant), .devReq(devReq),
    .cntZero(cntZero), .cntIsOne(cntIsOne), .pageLast(pageLast),
    .dpCtl(dpCtl), .busReq(busReq), .busy(busy), .pageWait(pageWait), .irq(irq)
  );

  dma_steal_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wdata(regWdata),
    .devRdata(devRdata), .memRdata(memRdata), .addr(addr), .cnt(cnt),
    .dir(dir), .cntZero(cntZero), .cntIsOne(cntIsOne), .pageLast(pageLast),
    .memWdata(memWdata), .devWdata(devWdata)
  );

  assign memEn   = dpCtl.step;
  assign devAck  = dpCtl.step;
  assign memWe   = dpCtl.step && !dir;
  assign memAddr = addr;

  always_comb begin
    case (regSel)
      SEL_ADDR: regRdata = REG_W'(addr);
      SEL_CNT:  regRdata = REG_W'(cnt);
      SEL_CTL:  regRdata = REG_W'({dir, 1'b0});
      default:  regRdata = REG_W'({irq, pageWait, busy});
    endcase
  end
endmodule

// File: tb/dma_steal_tb.sv
module dma_steal_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic regWe = 0;
  logic [1:0] regSel = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic busReq, busGrant = 0, devReq = 0, devAck;
  logic [7:0] devRdata, devWdata, memWdata, memRdata;
  logic memEn, memWe, irq;
  logic [15:0] memAddr;

  typedef struct {logic [15:0] a; logic we; logic [7:0] d;} item_t;
  item_t expQ[$];
  int total = 0, bad = 0, gCnt = 0;
  logic devEnable = 1;
  logic [7:0] seqCnt = 8'h10, seqExp = 8'h10;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_steal u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .busReq(busReq), .busGrant(busGrant), .devReq(devReq),
    .devAck(devAck), .devRdata(devRdata), .devWdata(devWdata), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .irq(irq)
  );

  assign memRdata = memAddr[7:0] ^ 8'hA5;
  assign devRdata = seqCnt;

  always @(posedge clk) begin
    #1;
    gCnt++;
    busGrant = (gCnt % 3) != 2;
    devReq = devEnable && ((gCnt % 5) != 4);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each access against the scoreboard
  always @(negedge clk) begin
    if (rstN && memEn) begin
      chk(busGrant && devAck && devReq, "R3 access without grant/ack", {busGrant, devAck, devReq}, 3'b111);
      if (expQ.size() == 0) begin
        chk(0, "R3/R7 unexpected access", memAddr, 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk(memAddr == e.a, "R6 address", memAddr, e.a);
        chk(memWe == e.we, "R4/R5 direction", memWe, e.we);
        if (e.we) chk(memWdata == e.d, "R4 write data", memWdata, e.d);
        else chk(devWdata == e.d, "R5 device data", devWdata, e.d);
      end
      if (memWe) seqCnt = seqCnt + 1;
    end
  end

  task automatic pushRun(input logic [15:0] a0, input int n, input bit m2d);
    for (int i = 0; i < n; i++) begin
      item_t e;
      e.a = a0 + 16'(i);
      e.we = !m2d;
      if (m2d) e.d = e.a[7:0] ^ 8'hA5;
      else begin e.d = seqExp; seqExp = seqExp + 1; end
      expQ.push_back(e);
    end
  endtask

  task automatic regWrite(input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1; regSel = s; regWdata = d;
    @(posedge clk); #1;
    regWe = 0; regWdata = 0;
  endtask

  task automatic regRead(input logic [1:0] s, output logic [31:0] v);
    @(posedge clk); #1;
    regSel = s;
    @(negedge clk);
    v = regRdata;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    chk(irq, req, irq, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(!irq && !busReq && !memEn && !devAck, "R1 reset outputs", {irq, busReq, memEn, devAck}, 0);
    regRead(2'd3, v);
    chk(v == 0, "R1 reset status", v, 0);

    // device to memory, 5 bytes
    regWrite(2'd0, 32'h0040);
    regWrite(2'd1, 32'd5);
    regRead(2'd0, v); chk(v == 32'h40, "R2 address readback", v, 32'h40);
    regRead(2'd1, v); chk(v == 5, "R2 count readback", v, 5);
    pushRun(16'h0040, 5, 0);
    regWrite(2'd2, 32'h1);
    regRead(2'd3, v); chk(v[0], "R2 busy while running", v, 1);
    waitIrq("R8 irq after last byte");
    regRead(2'd3, v); chk(v[0] == 0 && v[2], "R8/R11 status after done", v, 4);
    chk(expQ.size() == 0, "R6 all bytes moved", expQ.size(), 0);
    regRead(2'd0, v); chk(v == 32'h45, "R6 final address", v, 32'h45);
    regRead(2'd1, v); chk(v == 0, "R6 final count", v, 0);
    repeat (4) @(negedge clk);
    chk(irq, "R11 irq holds", irq, 1);
    regWrite(2'd3, 0);
    @(negedge clk);
    chk(!irq, "R11 irq cleared", irq, 0);

    // memory to device, 6 bytes
    regWrite(2'd0, 32'h1230);
    regWrite(2'd1, 32'd6);
    pushRun(16'h1230, 6, 1);
    regWrite(2'd2, 32'h3);
    regRead(2'd2, v); chk(v[1], "R2 direction readback", v, 2);
    waitIrq("R8 irq mem to dev");
    chk(expQ.size() == 0, "R5 all bytes delivered", expQ.size(), 0);
    regWrite(2'd3, 0);

    // page crossing
    regWrite(2'd0, 32'h00FC);
    regWrite(2'd1, 32'd8);
    pushRun(16'h00FC, 4, 0);
    regWrite(2'd2, 32'h1);
    begin
      int n = 0;
      v = 0;
      while (!v[1] && n < 200) begin regRead(2'd3, v); n++; end
    end
    chk(v[1] && v[0], "R7 page wait flag", v, 3);
    repeat (10) @(negedge clk);
    chk(!busReq, "R7 no bus request in page wait", busReq, 0);
    chk(expQ.size() == 0 && !irq, "R7 first page only", expQ.size(), 0);
    regRead(2'd1, v); chk(v == 4, "R7 remaining count", v, 4);
    pushRun(16'h0300, 4, 0);
    regWrite(2'd0, 32'h0300);
    waitIrq("R8 irq after resumed page");
    chk(expQ.size() == 0, "R7 second page moved", expQ.size(), 0);
    regWrite(2'd3, 0);

    // zero count
    regWrite(2'd1, 32'd0);
    regWrite(2'd2, 32'h1);
    @(negedge clk);
    chk(irq, "R9 zero count irq", irq, 1);
    regRead(2'd3, v); chk(v[0] == 0, "R9 not busy", v, 4);
    regWrite(2'd3, 0);

    // start while busy
    devEnable = 0;
    regWrite(2'd0, 32'h0500);
    regWrite(2'd1, 32'd3);
    pushRun(16'h0500, 3, 0);
    regWrite(2'd2, 32'h1);
    regWrite(2'd1, 32'd9);
    regWrite(2'd2, 32'h3);
    regRead(2'd1, v); chk(v == 3, "R10 count kept", v, 3);
    regRead(2'd2, v); chk(v[1] == 0, "R10 direction kept", v, 0);
    devEnable = 1;
    waitIrq("R10 original transfer completes");
    chk(expQ.size() == 0, "R10 only original bytes", expQ.size(), 0);
    repeat (5) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule